// File: doc/BRIEF.md
# Two-Digit BCD Seconds Timer

This block keeps a two-digit decimal seconds count, from 00 up to 99, and presents each digit both as a BCD nibble and as a seven-segment pattern. A free-running prescaler divides the system clock into a tick that is one clock wide, and that tick steps a chain of decade stages. The count returns to 00 after 99 and flags that moment with a one-clock wrap pulse.

Every register runs on the one system clock. The stages advance only through clock enables: the units stage is enabled by the tick, and the tens stage by the tick and the units carry together. The number of clocks per second is a parameter. The default of 4,000,000 matches a 4 MHz clock, and a simulation can set it to a handful of cycles. The control pins are plain levels with no handshake. Reset is synchronous and active high. A low `run` freezes the whole timer.

Top module: `bcd_sec_timer`

## Requirements
- R1: With `rst` high at a rising edge, after that edge both digits read 0, `wrap` is 0, and the prescaler restarts, so the first advance needs a full second of running clocks.
- R2: While `run` is high and `rst` is low, the value advances by exactly one every TICKS_PER_SEC clocks, and at no other time.
- R3: The units digit counts 0 to 9. An advance from units 9 sets units to 0 and raises the tens digit by one.
- R4: An advance from 99 gives 00.
- R5: `wrap` is high for exactly the one clock in which the value is 99 and an advance takes effect at the next rising edge. It is low in every other cycle.
- R6: While `run` is low, both digits and the prescaler hold. On resume, the count of clocks left in the current second carries on from where it stopped.
- R7: Each segment output is active high, with bit order {g,f,e,d,c,b,a} (bit 6 = g, bit 0 = a). The patterns for 0 to 9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F and 6F (hex). A code from 10 to 15 gives 00.
- R8: Each BCD digit output always holds a value from 0 to 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Run enable; low freezes the timer |
| ones_bcd | output | 4 | Units digit, BCD |
| tens_bcd | output | 4 | Tens digit, BCD |
| ones_seg | output | 7 | Units segments {g,f,e,d,c,b,a} |
| tens_seg | output | 7 | Tens segments {g,f,e,d,c,b,a} |
| wrap | output | 1 | One-clock pulse on the 99 to 00 advance |

## Verification
A fault in the prescaler shows within one second of clocks, because the first advance lands on the wrong edge. A fault in the enable chain or in a stage's terminal decode shows at the next units rollover: the tens digit moves early or late, or the value sticks at 9. A wrong wrap condition shows only around 99, so the bench runs through a full hundred seconds and checks every cycle. A seven-segment fault shows the moment the digit concerned takes the affected value.

// File: rtl/bcd_timer_pkg.sv
package bcd_timer_pkg;
  localparam int NUM_DIGITS = 2;
  localparam int BCD_W      = 4;
  localparam int SEG_W      = 7;

  typedef logic [BCD_W-1:0] bcd_t;
  typedef logic [SEG_W-1:0] seg_t;

  localparam bcd_t BCD_LAST = 4'd9;
endpackage

// File: rtl/sec_prescaler.sv
module sec_prescaler #(
  parameter int TICKS_PER_SEC = 4_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

  logic [CW-1:0] cnt_q;
  logic          at_last;

  assign at_last = (cnt_q == LAST);
  assign tick    = run & ~rst & at_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (run) begin
      if (at_last) cnt_q <= '0;
      else         cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/bcd_decade_stage.sv
module bcd_decade_stage
  import bcd_timer_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en,
  output bcd_t q,
  output logic carry
);
  bcd_t q_r;

  // terminal state flags a carry only while enabled
  assign carry = en & (q_r == BCD_LAST);
  assign q     = q_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      q_r <= '0;
    end else if (en) begin
      // 9 and any illegal code 10..15 both go to 0
      if (q_r >= BCD_LAST) q_r <= '0;
      else                 q_r <= q_r + 1'b1;
    end
  end
endmodule

// File: rtl/bcd_seg_decoder.sv
module bcd_seg_decoder
  import bcd_timer_pkg::*;
(
  input  bcd_t digit,
  output seg_t seg
);
  // bit order {g,f,e,d,c,b,a}, active high
  always_comb begin
    unique case (digit)
      4'd0:    seg = 7'h3F;
      4'd1:    seg = 7'h06;
      4'd2:    seg = 7'h5B;
      4'd3:    seg = 7'h4F;
      4'd4:    seg = 7'h66;
      4'd5:    seg = 7'h6D;
      4'd6:    seg = 7'h7D;
      4'd7:    seg = 7'h07;
      4'd8:    seg = 7'h7F;
      4'd9:    seg = 7'h6F;
      default: seg = 7'h00;
    endcase
  end
endmodule

// File: rtl/bcd_sec_timer.sv
module bcd_sec_timer
  import bcd_timer_pkg::*;
#(
  parameter int TICKS_PER_SEC = 4_000_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  output logic [3:0] ones_bcd,
  output logic [3:0] tens_bcd,
  output logic [6:0] ones_seg,
  output logic [6:0] tens_seg,
  output logic       wrap
);
  logic tick;
  logic [NUM_DIGITS:0]   stage_en;
  logic [NUM_DIGITS-1:0] stage_carry;
  bcd_t                  digit_q [NUM_DIGITS];
  seg_t                  digit_seg [NUM_DIGITS];

  sec_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_presc (
    .clk (clk),
    .rst (rst),
    .run (run),
    .tick(tick)
  );

  assign stage_en[0] = tick;

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_digit
    bcd_decade_stage u_stage (
      .clk  (clk),
      .rst  (rst),
      .en   (stage_en[i]),
      .q    (digit_q[i]),
      .carry(stage_carry[i])
    );
    // each higher stage advances only on the lower stage's carry
    assign stage_en[i+1] = stage_carry[i];

    bcd_seg_decoder u_dec (
      .digit(digit_q[i]),
      .seg  (digit_seg[i])
    );
  end

  assign ones_bcd = digit_q[0];
  assign tens_bcd = digit_q[1];
  assign ones_seg = digit_seg[0];
  assign tens_seg = digit_seg[1];
  assign wrap     = stage_en[NUM_DIGITS];
endmodule

// File: rtl/bcd_sec_timer_chk.sv
module bcd_sec_timer_chk (
  input logic       clk,
  input logic       rst,
  input logic       run,
  input logic [3:0] ones_bcd,
  input logic [3:0] tens_bcd,
  input logic [6:0] ones_seg,
  input logic [6:0] tens_seg,
  input logic       wrap
);
  p_digit_range_r8: assert property (@(posedge clk) disable iff (rst)
    (ones_bcd <= 4'd9) && (tens_bcd <= 4'd9));

  p_hold_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !run |=> ($stable(ones_bcd) && $stable(tens_bcd)));

  p_wrap_at_max_r5: assert property (@(posedge clk) disable iff (rst)
    wrap |-> (run && ones_bcd == 4'd9 && tens_bcd == 4'd9));

  p_wrap_to_zero_r4: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (ones_bcd == 4'd0 && tens_bcd == 4'd0));

  p_wrap_single_r5: assert property (@(posedge clk) disable iff (rst)
    wrap |=> !wrap);

  p_tens_follow_r3: assert property (@(posedge clk) disable iff (rst)
    (!rst && ones_bcd == 4'd9 && tens_bcd != 4'd9) ##1 (ones_bcd == 4'd0)
      |-> (tens_bcd == $past(tens_bcd) + 4'd1));

  p_seg_lit_r7: assert property (@(posedge clk) disable iff (rst)
    (ones_seg != 7'h00) && (tens_seg != 7'h00));
endmodule

bind bcd_sec_timer bcd_sec_timer_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .run     (run),
  .ones_bcd(ones_bcd),
  .tens_bcd(tens_bcd),
  .ones_seg(ones_seg),
  .tens_seg(tens_seg),
  .wrap    (wrap)
);

// File: tb/bcd_sec_timer_tb_top.sv
module bcd_sec_timer_tb_top;
  localparam int DIV = 4;

  // expected patterns {g,f,e,d,c,b,a} for digits 0..9 (R7)
  localparam logic [6:0] SEG_EXP [10] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66,
                                          7'h6D, 7'h7D, 7'h07, 7'h7F, 7'h6F};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       run = 1'b0;
  logic [3:0] ones_bcd, tens_bcd;
  logic [6:0] ones_seg, tens_seg;
  logic       wrap;

  int checks = 0;
  int errors = 0;
  int pc  = 0;
  int val = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bcd_sec_timer #(.TICKS_PER_SEC(DIV)) dut_i (
    .clk(clk), .rst(rst), .run(run),
    .ones_bcd(ones_bcd), .tens_bcd(tens_bcd),
    .ones_seg(ones_seg), .tens_seg(tens_seg),
    .wrap(wrap)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic verify(input string tag);
    int wexp;
    wexp = (run && !rst && pc == DIV-1 && val == 99) ? 1 : 0;
    check({tag, " ones"}, ones_bcd, val % 10);
    check({tag, " tens"}, tens_bcd, val / 10);
    check("R8 range", (ones_bcd <= 9 && tens_bcd <= 9) ? 1 : 0, 1);
    check("R7 ones_seg", ones_seg, SEG_EXP[val % 10]);
    check("R7 tens_seg", tens_seg, SEG_EXP[val / 10]);
    check("R5 wrap", wrap, wexp);
  endtask

  // drive at negedge, update model at posedge, check at next negedge
  task automatic cyc(input logic r_run, input logic r_rst, input string tag);
    run = r_run;
    rst = r_rst;
    @(posedge clk);
    if (r_rst) begin
      pc = 0; val = 0;
    end else if (r_run) begin
      if (pc == DIV-1) begin pc = 0; val = (val + 1) % 100; end
      else pc++;
    end
    @(negedge clk);
    verify(tag);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    cyc(1'b0, 1'b1, "R1");
    cyc(1'b1, 1'b1, "R1");
    // R2: first advance exactly DIV running clocks after reset
    for (int i = 0; i < DIV; i++) cyc(1'b1, 1'b0, "R2");
    check("R2 first step", ones_bcd, 1);
    // R3: main walk through units rollovers up to 98
    while (val < 98) cyc(1'b1, 1'b0, "R3");
    // R4: across 99 to 00
    while (val != 1) cyc(1'b1, 1'b0, "R4");
    // R6: pause mid-second, hold, then resume
    cyc(1'b1, 1'b0, "R6");
    cyc(1'b1, 1'b0, "R6");
    for (int i = 0; i < 10; i++) cyc(1'b0, 1'b0, "R6");
    for (int i = 0; i < 2 * DIV; i++) cyc(1'b1, 1'b0, "R6");
    // R1: reset mid-count, then restart timing
    cyc(1'b1, 1'b1, "R1");
    check("R1 cleared", {tens_bcd, ones_bcd}, 0);
    for (int i = 0; i < DIV + 1; i++) cyc(1'b1, 1'b0, "R1");
    // R5: pause at 99 with tick pending must not wrap
    while (!(val == 99 && pc == DIV-2)) cyc(1'b1, 1'b0, "R5");
    cyc(1'b1, 1'b0, "R5");
    cyc(1'b0, 1'b0, "R5");
    cyc(1'b0, 1'b0, "R5");
    cyc(1'b1, 1'b0, "R5");
    cyc(1'b1, 1'b0, "R5");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule